// File: doc/BRIEF.md
# Interrupt Source Controller

This block holds the state of a set of interrupt sources and turns their activity into present requests for a downstream presentation unit. Each source has a 32-bit destination server, an 8-bit priority and a saved priority. It also has a type bit that selects level-sensitive or message-signalled behaviour. A priority of 0xFF masks the source. Message sources remember arrivals that came in while masked and requests that the presenter turned down, and replay them later. Level sources keep a sent flag, so an active level is offered again after an end-of-interrupt or a rejection once a resend pass reaches it.

The presentation side returns three kinds of traffic. A reject or an end-of-interrupt names a global source number. A resend request walks all sources in order, one per cycle. At most one present request is offered per cycle. It carries the server, the priority and the global number, which is the local index plus a base offset. The request stays up until the presenter accepts it.

Top module: `irq_source_ctrl`

## Requirements
- R1: Reset gives every source priority 0xFF, saved priority 0xFF, server 0, cleared status flags and no request, and leaves each source's type bit as it was. `pres_valid` is low after reset.
- R2: A message source whose input is high in a cycle while its priority is not 0xFF offers a present request with its stored server and priority and global number BASE plus index. The request is visible the cycle after.
- R3: A message arrival while the priority is 0xFF presents nothing and sets the masked-pending flag. A later priority write other than 0xFF clears the flag and presents.
- R4: A level source's asserted flag follows its input. When the level changes, the source presents only if unmasked, asserted and not yet sent, and it sets sent when it presents. While sent is set, no further present happens.
- R5: A reject sets the rejected flag of a message source and clears the sent flag of a level source. Neither presents again until a resend reaches it.
- R6: An end-of-interrupt clears the sent flag of a level source and has no effect on a message source, including its rejected flag.
- R7: A configuration write stores server, priority and saved priority. For a level source it re-applies the R4 present rule with the new priority.
- R8: A resend visits the sources in ascending index. A rejected message source clears the flag and re-presents if unmasked. A level source applies the R4 rule.
- R9: Only one request is offered at a time, lowest index first. It is held until `pres_ready`, and the resend walk does not advance while a request waits unaccepted.
- R10: Reject and end-of-interrupt numbers outside BASE to BASE+NSRC-1 are ignored.
- R11: A type write stores the type bit: 1 selects level behaviour and 0 selects message behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Per-source input: a pulse for message sources, a level for level sources |
| type_we | input | 1 | Type bit write strobe |
| type_idx | input | IDX_W | Source index for the type write |
| type_lvl | input | 1 | 1 = level source, 0 = message source |
| cfg_we | input | 1 | Server and priority write strobe |
| cfg_idx | input | IDX_W | Source index for the configuration write |
| cfg_server | input | SRV_W | Destination server to store |
| cfg_prio | input | PRIO_W | Priority to store (all ones masks) |
| cfg_saved_prio | input | PRIO_W | Saved priority to store |
| rej_valid | input | 1 | Reject strobe from the presenter |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Start a resend walk |
| pres_ready | input | 1 | Presenter accepts the offered request |
| pres_valid | output | 1 | A present request is offered |
| pres_server | output | SRV_W | Destination server of the request |
| pres_num | output | NUM_W | Global source number of the request |
| pres_prio | output | PRIO_W | Priority of the request |

## Verification
Message sources are driven with randomly chosen servers, priorities and indices and single-cycle pulses, which separates correct field routing and offset arithmetic from mixed-up stored state. Directed sequences then tell the two source types apart: a held level presents once while a message input presents on every pulse. They also show that a reject, an end-of-interrupt or an out-of-range number changes only what the following resend walk offers. A walk started with the presenter not ready shows that the request is held and that the walk resumes in index order, one source per cycle. A reset in the middle of the run confirms that priorities return to masked while the type bits survive.

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl #(
  parameter int NSRC   = 8,
  parameter int SRV_W  = 32,
  parameter int PRIO_W = 8,
  parameter int NUM_W  = 24,
  parameter logic [NUM_W-1:0] BASE = 24'h1000,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              type_we,
  input  logic [IDX_W-1:0]  type_idx,
  input  logic              type_lvl,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [PRIO_W-1:0] cfg_saved_prio,
  input  logic              rej_valid,
  input  logic [NUM_W-1:0]  rej_num,
  input  logic              eoi_valid,
  input  logic [NUM_W-1:0]  eoi_num,
  input  logic              resend_req,
  input  logic              pres_ready,
  output logic              pres_valid,
  output logic [SRV_W-1:0]  pres_server,
  output logic [NUM_W-1:0]  pres_num,
  output logic [PRIO_W-1:0] pres_prio
);
  localparam logic [PRIO_W-1:0] MASKED = '1;
  localparam logic [IDX_W-1:0]  LAST   = IDX_W'(NSRC - 1);

  logic [SRV_W-1:0]  srv_q  [NSRC];
  logic [SRV_W-1:0]  srv_d  [NSRC];
  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [PRIO_W-1:0] prio_d [NSRC];
  logic [PRIO_W-1:0] sav_q  [NSRC];
  logic [PRIO_W-1:0] sav_d  [NSRC];
  logic [NSRC-1:0] asr_q, asr_d, sent_q, sent_d, rej_q, rej_d, mp_q, mp_d, req_q, req_d;
  logic [NSRC-1:0] lvl_q;

  logic             scan_on, scan_again;
  logic [IDX_W-1:0] scan_ptr;
  logic [IDX_W-1:0] sel;

  logic [NUM_W-1:0] rej_off, eoi_off;
  logic             rej_ok, eoi_ok, grant, stall, scan_step;

  assign rej_off   = rej_num - BASE;
  assign eoi_off   = eoi_num - BASE;
  assign rej_ok    = rej_valid && (rej_off < NUM_W'(NSRC));
  assign eoi_ok    = eoi_valid && (eoi_off < NUM_W'(NSRC));
  assign pres_valid = |req_q;
  assign grant     = pres_valid && pres_ready;
  assign stall     = pres_valid && !pres_ready;
  assign scan_step = scan_on && !stall;

  always_comb begin
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req_q[i]) sel = IDX_W'(i);
  end

  assign pres_server = srv_q[sel];
  assign pres_prio   = prio_q[sel];
  assign pres_num    = BASE + NUM_W'(sel);

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      logic ev;
      ev        = 1'b0;
      srv_d[i]  = srv_q[i];
      prio_d[i] = prio_q[i];
      sav_d[i]  = sav_q[i];
      asr_d[i]  = asr_q[i];
      sent_d[i] = sent_q[i];
      rej_d[i]  = rej_q[i];
      mp_d[i]   = mp_q[i];
      req_d[i]  = req_q[i];
      if (grant && sel == IDX_W'(i)) req_d[i] = 1'b0;
      if (rej_ok && rej_off == NUM_W'(i)) begin
        if (lvl_q[i]) sent_d[i] = 1'b0;
        else          rej_d[i]  = 1'b1;
      end
      if (eoi_ok && eoi_off == NUM_W'(i) && lvl_q[i]) sent_d[i] = 1'b0;
      if (cfg_we && cfg_idx == IDX_W'(i)) begin
        srv_d[i]  = cfg_server;
        prio_d[i] = cfg_prio;
        sav_d[i]  = cfg_saved_prio;
        if (lvl_q[i]) ev = 1'b1;
        else if (mp_d[i] && cfg_prio != MASKED) begin
          mp_d[i]  = 1'b0;
          req_d[i] = 1'b1;
        end
      end
      if (lvl_q[i]) begin
        if (src_in[i] != asr_q[i]) begin
          asr_d[i] = src_in[i];
          ev = 1'b1;
        end
      end else if (src_in[i]) begin
        if (prio_d[i] == MASKED) mp_d[i]  = 1'b1;
        else                     req_d[i] = 1'b1;
      end
      if (scan_step && scan_ptr == IDX_W'(i)) begin
        if (lvl_q[i]) ev = 1'b1;
        else if (rej_d[i]) begin
          rej_d[i] = 1'b0;
          if (prio_d[i] != MASKED) req_d[i] = 1'b1;
        end
      end
      if (ev && prio_d[i] != MASKED && asr_d[i] && !sent_d[i]) begin
        sent_d[i] = 1'b1;
        req_d[i]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        srv_q[i]  <= '0;
        prio_q[i] <= MASKED;
        sav_q[i]  <= MASKED;
      end
      asr_q  <= '0;
      sent_q <= '0;
      rej_q  <= '0;
      mp_q   <= '0;
      req_q  <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        srv_q[i]  <= srv_d[i];
        prio_q[i] <= prio_d[i];
        sav_q[i]  <= sav_d[i];
      end
      asr_q  <= asr_d;
      sent_q <= sent_d;
      rej_q  <= rej_d;
      mp_q   <= mp_d;
      req_q  <= req_d;
    end
  end

  always_ff @(posedge clk)
    for (int i = 0; i < NSRC; i++)
      if (type_we && type_idx == IDX_W'(i)) lvl_q[i] <= type_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_on    <= 1'b0;
      scan_again <= 1'b0;
      scan_ptr   <= '0;
    end else if (resend_req && !scan_on) begin
      scan_on  <= 1'b1;
      scan_ptr <= '0;
    end else if (scan_on) begin
      if (resend_req) scan_again <= 1'b1;
      if (scan_step) begin
        if (scan_ptr == LAST) begin
          scan_ptr   <= '0;
          scan_again <= 1'b0;
          if (!(scan_again || resend_req)) scan_on <= 1'b0;
        end else begin
          scan_ptr <= scan_ptr + 1'b1;
        end
      end
    end
  end

  a_r9_walk_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_on && pres_valid && !pres_ready) |=> $stable(scan_ptr));

  for (genvar g = 0; g < NSRC; g++) begin : g_chk
    a_r3_masked_arrival: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_q[g] && src_in[g] && prio_q[g] == MASKED && !(cfg_we && cfg_idx == IDX_W'(g)))
      |=> mp_q[g]);
    a_r5_msg_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_q[g] && rej_ok && rej_off == NUM_W'(g) && !(scan_step && scan_ptr == IDX_W'(g)))
      |=> rej_q[g]);
    a_r6_lvl_eoi: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q[g] && eoi_ok && eoi_off == NUM_W'(g) && src_in[g] == asr_q[g]
       && !(cfg_we && cfg_idx == IDX_W'(g)) && !(scan_step && scan_ptr == IDX_W'(g)))
      |=> !sent_q[g]);
    a_r7_saved_stored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_idx == IDX_W'(g)) |=> sav_q[g] == $past(cfg_saved_prio));
  end
endmodule

// File: tb/test_irq_source_ctrl.sv
module test_irq_source_ctrl;
  localparam int N = 8;
  localparam logic [23:0] BASE = 24'h1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic type_we = 0, type_lvl = 0, cfg_we = 0, rej_valid = 0, eoi_valid = 0, resend_req = 0;
  logic pres_ready = 1'b1;
  logic [2:0] type_idx = '0, cfg_idx = '0;
  logic [31:0] cfg_server = '0;
  logic [7:0] cfg_prio = '0, cfg_saved_prio = '0;
  logic [23:0] rej_num = '0, eoi_num = '0;
  logic pres_valid;
  logic [31:0] pres_server;
  logic [23:0] pres_num;
  logic [7:0] pres_prio;

  irq_source_ctrl #(.NSRC(N), .BASE(BASE)) i_irq_source_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .type_we(type_we), .type_idx(type_idx),
    .type_lvl(type_lvl), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
    .cfg_prio(cfg_prio), .cfg_saved_prio(cfg_saved_prio), .rej_valid(rej_valid),
    .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_req(resend_req),
    .pres_ready(pres_ready), .pres_valid(pres_valid), .pres_server(pres_server),
    .pres_num(pres_num), .pres_prio(pres_prio));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] srv_m [N];
  logic [7:0]  prio_m [N];

  function automatic logic [23:0] exp_num(int i);
    return BASE + 24'(i);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cfg(int i, logic [31:0] s, logic [7:0] p);
    cfg_we = 1; cfg_idx = 3'(i); cfg_server = s; cfg_prio = p; cfg_saved_prio = ~p;
    srv_m[i] = s; prio_m[i] = p;
    step();
    cfg_we = 0;
  endtask

  task automatic pulse(int i);
    src_in[i] = 1'b1;
    step();
    src_in[i] = 1'b0;
  endtask

  task automatic reject(logic [23:0] n);
    rej_valid = 1; rej_num = n; step(); rej_valid = 0;
  endtask

  task automatic eoi(logic [23:0] n);
    eoi_valid = 1; eoi_num = n; step(); eoi_valid = 0;
  endtask

  task automatic resend();
    resend_req = 1; step(); resend_req = 0;
  endtask

  task automatic expect_pres(string req, int i);
    chk(pres_valid == 1'b1, req, "pres_valid", 64'(pres_valid), 64'd1);
    chk(pres_num == exp_num(i), req, "pres_num", 64'(pres_num), 64'(exp_num(i)));
    chk(pres_server == srv_m[i], req, "pres_server", 64'(pres_server), 64'(srv_m[i]));
    chk(pres_prio == prio_m[i], req, "pres_prio", 64'(pres_prio), 64'(prio_m[i]));
  endtask

  task automatic expect_none(string req, int n);
    bit seen = 0;
    logic [23:0] num = '0;
    for (int k = 0; k < n; k++) begin
      if (pres_valid && !seen) begin seen = 1; num = pres_num; end
      step();
    end
    chk(!seen, req, "unexpected present", 64'(num), 64'd0);
  endtask

  task automatic wait_pres(int n);
    for (int k = 0; k < n && !pres_valid; k++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin srv_m[i] = '0; prio_m[i] = 8'hFF; end
    // R11: sources 4..7 are level, 0..3 message
    repeat (2) step();
    for (int i = 0; i < N; i++) begin
      type_we = 1; type_idx = 3'(i); type_lvl = (i >= 4); step();
    end
    type_we = 0;
    step(); rst_n = 1; step();
    chk(pres_valid == 1'b0, "R1", "pres_valid after reset", 64'(pres_valid), 64'd0);

    // R1/R3: reset priority masks the message source
    pulse(0);
    expect_none("R3", 4);
    cfg(0, 32'hA5, 8'd5);
    expect_pres("R3", 0);
    step();
    expect_none("R3", 3);

    // R2: random message traffic
    for (int k = 0; k < 20; k++) begin
      int i = $urandom_range(0, 3);
      cfg(i, $urandom, 8'($urandom_range(0, 254)));
      pulse(i);
      expect_pres("R2", i);
      step();
    end

    // R4: level source presents once per sent cycle
    cfg(4, 32'h44, 8'd3);
    expect_none("R4", 2);
    src_in[4] = 1; step();
    expect_pres("R4", 4);
    step();
    expect_none("R4", 5);
    src_in[4] = 0; step(); src_in[4] = 1; step();
    expect_none("R4", 4);

    // R6/R8: EOI on level, then resend re-presents
    eoi(exp_num(4));
    expect_none("R6", 3);
    resend();
    wait_pres(N + 4);
    expect_pres("R6", 4);
    step();
    expect_none("R8", N + 4);

    // R5: reject on level
    reject(exp_num(4));
    expect_none("R5", 3);
    resend(); wait_pres(N + 4);
    expect_pres("R5", 4);
    step(); expect_none("R5", N + 4);

    // R5/R8: reject on message, replay once
    cfg(1, 32'h1111, 8'd7);
    pulse(1); expect_pres("R2", 1); step();
    reject(exp_num(1));
    expect_none("R5", 3);
    resend(); wait_pres(N + 4);
    expect_pres("R8", 1);
    step(); expect_none("R8", 2);
    resend(); expect_none("R8", N + 4);

    // R6: EOI does not clear message rejected flag
    cfg(2, 32'h2222, 8'd9);
    pulse(2); step();
    reject(exp_num(2));
    eoi(exp_num(2));
    resend(); wait_pres(N + 4);
    expect_pres("R6", 2);
    step(); expect_none("R6", N + 4);

    // R10: out-of-range numbers are ignored
    cfg(3, 32'h3333, 8'd2);
    pulse(3); step();
    reject(24'd3);
    reject(exp_num(N));
    resend(); expect_none("R10", N + 4);
    reject(exp_num(3));
    resend(); wait_pres(N + 4);
    expect_pres("R10", 3);
    step(); expect_none("R10", N + 4);

    // R7: level source unmasked by config write
    src_in[5] = 1; step();
    expect_none("R7", 3);
    cfg(5, 32'h5555, 8'd1);
    expect_pres("R7", 5);
    step(); expect_none("R7", 3);

    // R9: stalled walk and ascending order
    for (int i = 0; i < 3; i++) begin pulse(i); step(); end
    for (int i = 0; i < 3; i++) reject(exp_num(i));
    pres_ready = 0;
    resend();
    repeat (5) step();
    expect_pres("R9", 0);
    repeat (3) step();
    expect_pres("R9", 0);
    pres_ready = 1;
    step();
    for (int i = 1; i < 3; i++) begin
      expect_pres("R9", i);
      step();
    end
    expect_none("R9", N + 4);

    // R1/R11: reset keeps types, masks priorities
    src_in = '0; step();
    rst_n = 0; repeat (2) step(); rst_n = 1; step();
    chk(pres_valid == 1'b0, "R1", "pres_valid after second reset", 64'(pres_valid), 64'd0);
    pulse(0);
    expect_none("R1", 3);
    cfg(6, 32'h6666, 8'd4);
    expect_none("R11", 2);
    src_in[6] = 1; step();
    expect_pres("R11", 6);
    step();
    expect_none("R11", 4);
    src_in = '0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule